// File: doc/BRIEF.md
# Write-Back Update Coherence Controller

This block is the coherence controller of one cache in a snooping multiprocessor that keeps shared data consistent by updating peer copies rather than invalidating them. It holds a small direct-mapped set of lines, one data word per line. A resident line is always in one of four states: exclusive-clean, modified, shared-clean or shared-modified. There is no invalid state for a line that is present. The controller serves processor reads and writes. It issues bus reads, bus updates and writebacks. It also snoops the transactions of the other caches.

A wired-OR shared signal tells the controller whether other caches hold the line during its own read or update. The controller drives its contribution to that signal when a snooped address hits one of its lines. When a write hits a shared line, the new word goes to the other caches only, and memory stays stale. Responsibility for memory then rests with one shared-modified owner, which writes the line back when it evicts it. Every bus transaction is atomic and completes in the cycle in which it is granted. A snooped transaction never falls in the same cycle as a grant to this cache.

Top module: `upd_coh_ctrl`

## Requirements
- R1: While rst_ni is low and after it rises, no line is resident, and cpu_ready_o, bus_req_o, snp_shared_o and snp_supply_o are low until a request arrives.
- R2: A read miss issues a bus read (bus_cmd_o = 0) at the requested address. In the grant cycle the line is filled from bus_rdata_i, exclusive-clean if bus_shared_i is low and shared-clean if it is high. The request then completes as a hit.
- R3: A read hit raises cpu_ready_o in the same cycle with the line word on cpu_rdata_o, and makes no bus request.
- R4: A write hit on an exclusive-clean or modified line completes in the same cycle with no bus transaction and leaves the line modified.
- R5: A write hit on a shared-clean or shared-modified line issues a bus update (bus_cmd_o = 1) carrying the address and the new word. cpu_ready_o rises in the grant cycle. The line becomes shared-modified if bus_shared_i is high in that cycle and modified otherwise.
- R6: A write miss first fills the line as in R2, then completes as a write hit as in R4 or R5.
- R7: snp_shared_o is high in exactly those cycles where snp_valid_i is high and snp_addr_i hits a resident line.
- R8: A snooped read (snp_cmd_i = 0) that hits a modified or shared-modified line raises snp_supply_o with the line word on snp_data_o and leaves the line shared-modified. A hit on an exclusive-clean line makes it shared-clean. A hit on a shared-clean line does not supply data.
- R9: A snooped update (snp_cmd_i = 1) that hits replaces the line word with snp_wdata_i and leaves the line shared-clean, even if it was shared-modified. A snooped update that misses changes nothing.
- R10: A miss whose victim is modified or shared-modified first issues a writeback (bus_cmd_o = 2) of the victim address and word, then the bus read. A clean victim is replaced with no writeback.
- R11: No processor request completes in a cycle where snp_valid_i is high. A snooped update may change a line while this cache waits for the grant of its own update. The pending write still applies in the grant cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until cpu_ready_o |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address; low bits select the line |
| cpu_wdata_i | input | DATA_W | Write word |
| cpu_ready_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | DATA_W | Read word, valid with cpu_ready_o |
| bus_req_o | output | 1 | Bus transaction requested |
| bus_cmd_o | output | 2 | 0 read, 1 update, 2 writeback |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_wdata_o | output | DATA_W | Update or writeback word |
| bus_gnt_i | input | 1 | Grant; the transaction completes this cycle |
| bus_shared_i | input | 1 | Wired-OR shared signal from the other caches |
| bus_rdata_i | input | DATA_W | Fill word for a bus read |
| snp_valid_i | input | 1 | Another cache's transaction is on the bus |
| snp_cmd_i | input | 2 | Snooped command, same encoding as bus_cmd_o |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_wdata_i | input | DATA_W | Snooped update word |
| snp_shared_o | output | 1 | This cache holds the snooped line |
| snp_supply_o | output | 1 | This cache supplies the snooped read data |
| snp_data_o | output | DATA_W | Supplied word |

## Verification
The bench drives a shared-modified line through a snooped update. A design that kept the owner role would go on supplying data on the next snooped read, while memory would never receive the line. Replacing a line that was written under a low shared signal must produce a writeback, and the word written back must come back through a later refill. A controller that treated that line as clean would silently lose the word. The bench also holds back the grant of a pending update while a snooped update hits the same line. The processor word must win, and a controller that completed processor requests during snoops would acknowledge too early. A snoop to an absent tag that shares an index with a resident line must report no sharing.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LS_EXCL  = 2'd0,
    LS_SHCLN = 2'd1,
    LS_SHMOD = 2'd2,
    LS_MOD   = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BC_READ   = 2'd0,
    BC_UPDATE = 2'd1,
    BC_WBACK  = 2'd2,
    BC_IDLE   = 2'd3
  } bus_cmd_e;

  function automatic logic is_dirty(line_st_e st);
    return (st == LS_MOD) || (st == LS_SHMOD);
  endfunction
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 6,
  parameter int DATA_W    = 16,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  a_idx_i,
  output logic              a_vld_o,
  output logic [TAG_W-1:0]  a_tag_o,
  output line_st_e          a_st_o,
  output logic [DATA_W-1:0] a_data_o,
  input  logic [IDX_W-1:0]  b_idx_i,
  output logic              b_vld_o,
  output logic [TAG_W-1:0]  b_tag_o,
  output line_st_e          b_st_o,
  output logic [DATA_W-1:0] b_data_o,
  input  logic              w0_en_i,
  input  logic [IDX_W-1:0]  w0_idx_i,
  input  logic [TAG_W-1:0]  w0_tag_i,
  input  line_st_e          w0_st_i,
  input  logic [DATA_W-1:0] w0_data_i,
  input  logic              w1_en_i,
  input  logic [IDX_W-1:0]  w1_idx_i,
  input  line_st_e          w1_st_i,
  input  logic [DATA_W-1:0] w1_data_i
);
  logic              vld_q  [NUM_LINES];
  logic [TAG_W-1:0]  tag_q  [NUM_LINES];
  line_st_e          st_q   [NUM_LINES];
  logic [DATA_W-1:0] data_q [NUM_LINES];

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[l]  <= 1'b0;
        tag_q[l]  <= '0;
        st_q[l]   <= LS_EXCL;
        data_q[l] <= '0;
      end else if (w0_en_i && w0_idx_i == IDX_W'(l)) begin
        vld_q[l]  <= 1'b1;
        tag_q[l]  <= w0_tag_i;
        st_q[l]   <= w0_st_i;
        data_q[l] <= w0_data_i;
      end else if (w1_en_i && w1_idx_i == IDX_W'(l)) begin
        st_q[l]   <= w1_st_i;
        data_q[l] <= w1_data_i;
      end
    end
  end

  assign a_vld_o  = vld_q[a_idx_i];
  assign a_tag_o  = tag_q[a_idx_i];
  assign a_st_o   = st_q[a_idx_i];
  assign a_data_o = data_q[a_idx_i];
  assign b_vld_o  = vld_q[b_idx_i];
  assign b_tag_o  = tag_q[b_idx_i];
  assign b_st_o   = st_q[b_idx_i];
  assign b_data_o = data_q[b_idx_i];

  // own transactions and snoops never share a cycle
  a_r11_one_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(w0_en_i && w1_en_i));
endmodule

// File: rtl/coh_snoop.sv
module coh_snoop
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic [DATA_W-1:0] snp_wdata_i,
  input  logic              line_vld_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  line_st_e          line_st_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              shared_o,
  output logic              supply_o,
  output logic [DATA_W-1:0] data_o,
  output logic              wr_en_o,
  output line_st_e          wr_st_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic hit;
  assign hit      = snp_valid_i && line_vld_i && (line_tag_i == snp_addr_i[ADDR_W-1:IDX_W]);
  assign shared_o = hit;
  assign data_o   = line_data_i;

  always_comb begin
    supply_o  = 1'b0;
    wr_en_o   = 1'b0;
    wr_st_o   = line_st_i;
    wr_data_o = line_data_i;
    if (hit) begin
      unique case (bus_cmd_e'(snp_cmd_i))
        BC_READ: begin
          supply_o = is_dirty(line_st_i);
          wr_en_o  = 1'b1;
          wr_st_o  = is_dirty(line_st_i) ? LS_SHMOD : LS_SHCLN;
        end
        BC_UPDATE: begin
          wr_en_o   = 1'b1;
          wr_st_o   = LS_SHCLN;
          wr_data_o = snp_wdata_i;
        end
        default: ;
      endcase
    end
  end

  a_r8_supply_only_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_o |-> shared_o && snp_cmd_i == BC_READ);
  a_r7_no_share_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snp_valid_i |-> !shared_o && !supply_o);
endmodule

// File: rtl/coh_fsm.sv
module coh_fsm
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              snp_busy_i,
  input  logic              line_vld_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  line_st_e          line_st_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_gnt_i,
  input  logic              bus_shared_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              wr_en_o,
  output logic [TAG_W-1:0]  wr_tag_o,
  output line_st_e          wr_st_o,
  output logic [DATA_W-1:0] wr_data_o
);
  typedef enum logic [1:0] {F_IDLE, F_EVICT, F_FILL, F_UPD} fsm_e;
  fsm_e state_q, state_d;

  logic [TAG_W-1:0] cpu_tag;
  logic [IDX_W-1:0] cpu_idx;
  logic             hit, dirty;
  assign cpu_tag = cpu_addr_i[ADDR_W-1:IDX_W];
  assign cpu_idx = cpu_addr_i[IDX_W-1:0];
  assign hit     = line_vld_i && (line_tag_i == cpu_tag);
  assign dirty   = line_vld_i && is_dirty(line_st_i);
  assign cpu_rdata_o = line_data_i;

  always_comb begin
    state_d     = state_q;
    cpu_ready_o = 1'b0;
    bus_req_o   = 1'b0;
    bus_cmd_o   = BC_IDLE;
    bus_addr_o  = cpu_addr_i;
    bus_wdata_o = cpu_wdata_i;
    wr_en_o     = 1'b0;
    wr_tag_o    = line_tag_i;
    wr_st_o     = line_st_i;
    wr_data_o   = line_data_i;
    unique case (state_q)
      F_IDLE: if (cpu_req_i && !snp_busy_i) begin
        if (!hit) begin
          state_d = dirty ? F_EVICT : F_FILL;
        end else if (!cpu_we_i) begin
          cpu_ready_o = 1'b1;
        end else if (line_st_i == LS_EXCL || line_st_i == LS_MOD) begin
          cpu_ready_o = 1'b1;
          wr_en_o     = 1'b1;
          wr_st_o     = LS_MOD;
          wr_data_o   = cpu_wdata_i;
        end else begin
          state_d = F_UPD;
        end
      end
      F_EVICT: begin
        // a snoop may have cleaned the victim meanwhile
        if (dirty) begin
          bus_req_o   = 1'b1;
          bus_cmd_o   = BC_WBACK;
          bus_addr_o  = {line_tag_i, cpu_idx};
          bus_wdata_o = line_data_i;
          if (bus_gnt_i) begin
            wr_en_o = 1'b1;
            wr_st_o = LS_SHCLN;
            state_d = F_FILL;
          end
        end else begin
          state_d = F_FILL;
        end
      end
      F_FILL: begin
        bus_req_o = 1'b1;
        bus_cmd_o = BC_READ;
        if (bus_gnt_i) begin
          wr_en_o   = 1'b1;
          wr_tag_o  = cpu_tag;
          wr_st_o   = bus_shared_i ? LS_SHCLN : LS_EXCL;
          wr_data_o = bus_rdata_i;
          state_d   = F_IDLE;
        end
      end
      F_UPD: begin
        bus_req_o = 1'b1;
        bus_cmd_o = BC_UPDATE;
        if (bus_gnt_i) begin
          cpu_ready_o = 1'b1;
          wr_en_o     = 1'b1;
          wr_st_o     = bus_shared_i ? LS_SHMOD : LS_MOD;
          wr_data_o   = cpu_wdata_i;
          state_d     = F_IDLE;
        end
      end
      default: state_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= F_IDLE;
    else         state_q <= state_d;
  end

  a_r3_read_hit_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == F_IDLE && cpu_req_i && !cpu_we_i && hit && !snp_busy_i
      |-> cpu_ready_o && !bus_req_o);
  a_r4_sole_write_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == F_IDLE && cpu_req_i && cpu_we_i && hit && !snp_busy_i &&
      (line_st_i == LS_EXCL || line_st_i == LS_MOD) |-> cpu_ready_o && !bus_req_o);
  a_r5_shared_write_updates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == F_IDLE && cpu_req_i && cpu_we_i && hit && !snp_busy_i &&
      (line_st_i == LS_SHCLN || line_st_i == LS_SHMOD) |=> bus_req_o && bus_cmd_o == BC_UPDATE);
  a_r10_read_after_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_gnt_i && bus_cmd_o == BC_WBACK |=> bus_req_o && bus_cmd_o == BC_READ);
  a_r11_no_ready_in_snoop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_busy_i |-> !cpu_ready_o);
endmodule

// File: rtl/upd_coh_ctrl.sv
module upd_coh_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int NUM_LINES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_gnt_i,
  input  logic              bus_shared_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic [DATA_W-1:0] snp_wdata_i,
  output logic              snp_shared_o,
  output logic              snp_supply_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              a_vld, b_vld;
  logic [TAG_W-1:0]  a_tag, b_tag;
  line_st_e          a_st, b_st;
  logic [DATA_W-1:0] a_data, b_data;
  logic              w0_en, w1_en;
  logic [TAG_W-1:0]  w0_tag;
  line_st_e          w0_st, w1_st;
  logic [DATA_W-1:0] w0_data, w1_data;

  coh_line_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .a_idx_i(cpu_addr_i[IDX_W-1:0]), .a_vld_o(a_vld), .a_tag_o(a_tag),
    .a_st_o(a_st), .a_data_o(a_data),
    .b_idx_i(snp_addr_i[IDX_W-1:0]), .b_vld_o(b_vld), .b_tag_o(b_tag),
    .b_st_o(b_st), .b_data_o(b_data),
    .w0_en_i(w0_en), .w0_idx_i(cpu_addr_i[IDX_W-1:0]), .w0_tag_i(w0_tag),
    .w0_st_i(w0_st), .w0_data_i(w0_data),
    .w1_en_i(w1_en), .w1_idx_i(snp_addr_i[IDX_W-1:0]), .w1_st_i(w1_st),
    .w1_data_i(w1_data)
  );

  coh_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni,
    .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i, .cpu_ready_o, .cpu_rdata_o,
    .snp_busy_i(snp_valid_i),
    .line_vld_i(a_vld), .line_tag_i(a_tag), .line_st_i(a_st), .line_data_i(a_data),
    .bus_req_o, .bus_cmd_o, .bus_addr_o, .bus_wdata_o,
    .bus_gnt_i, .bus_shared_i, .bus_rdata_i,
    .wr_en_o(w0_en), .wr_tag_o(w0_tag), .wr_st_o(w0_st), .wr_data_o(w0_data)
  );

  coh_snoop #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
    .clk_i, .rst_ni,
    .snp_valid_i, .snp_cmd_i, .snp_addr_i, .snp_wdata_i,
    .line_vld_i(b_vld), .line_tag_i(b_tag), .line_st_i(b_st), .line_data_i(b_data),
    .shared_o(snp_shared_o), .supply_o(snp_supply_o), .data_o(snp_data_o),
    .wr_en_o(w1_en), .wr_st_o(w1_st), .wr_data_o(w1_data)
  );

  a_r11_snoop_not_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i |-> !(bus_req_o && bus_gnt_i));
  a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !bus_req_o && !snp_shared_o);
endmodule

// File: tb/upd_coh_ctrl_test.sv
`timescale 1ns/1ps
module upd_coh_ctrl_test;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req_i = 0, cpu_we_i = 0;
  logic [AW-1:0] cpu_addr_i = '0;
  logic [DW-1:0] cpu_wdata_i = '0;
  logic cpu_ready_o;
  logic [DW-1:0] cpu_rdata_o;
  logic bus_req_o;
  logic [1:0] bus_cmd_o;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_wdata_o;
  logic bus_gnt_i = 0, bus_shared_i = 0;
  logic [DW-1:0] bus_rdata_i = '0;
  logic snp_valid_i = 0;
  logic [1:0] snp_cmd_i = '0;
  logic [AW-1:0] snp_addr_i = '0;
  logic [DW-1:0] snp_wdata_i = '0;
  logic snp_shared_o, snp_supply_o;
  logic [DW-1:0] snp_data_o;

  always #10 clk = ~clk;

  upd_coh_ctrl #(.ADDR_W(AW), .DATA_W(DW), .NUM_LINES(4)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i, .cpu_ready_o, .cpu_rdata_o,
    .bus_req_o, .bus_cmd_o, .bus_addr_o, .bus_wdata_o, .bus_gnt_i, .bus_shared_i, .bus_rdata_i,
    .snp_valid_i, .snp_cmd_i, .snp_addr_i, .snp_wdata_i,
    .snp_shared_o, .snp_supply_o, .snp_data_o
  );

  typedef struct packed {logic [1:0] cmd; logic [AW-1:0] addr; logic [DW-1:0] data;} txn_t;
  txn_t exp_q[$];
  logic [DW-1:0] mem [256];
  int n_chk = 0, n_err = 0;
  bit shared_cfg = 0, hold_gnt = 0, done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] cmd, input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_q.push_back('{cmd, a, d});
  endtask

  // bus model and transaction monitor
  always @(negedge clk) begin
    #2;
    if (rst_n && bus_req_o && !hold_gnt) begin
      txn_t e;
      bus_gnt_i    = 1'b1;
      bus_shared_i = shared_cfg;
      bus_rdata_i  = mem[bus_addr_o];
      if (exp_q.size() == 0) begin
        check(0, "R4/R10", "unexpected bus transaction", {22'd0, bus_cmd_o, bus_addr_o}, 32'hffff);
      end else begin
        e = exp_q.pop_front();
        check(bus_cmd_o == e.cmd && bus_addr_o == e.addr &&
              (e.cmd == 2'd0 || bus_wdata_o == e.data), "R2/R5/R10", "bus transaction",
              {bus_cmd_o, 6'd0, bus_addr_o, bus_wdata_o}, {e.cmd, 6'd0, e.addr, e.data});
      end
      if (bus_cmd_o == 2'd2) mem[bus_addr_o] = bus_wdata_o;
    end else begin
      bus_gnt_i = 1'b0;
    end
  end

  task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit chk_rd, input logic [DW-1:0] exp, input string req);
    int cyc = 0;
    @(negedge clk);
    cpu_req_i = 1; cpu_we_i = we; cpu_addr_i = a; cpu_wdata_i = d;
    forever begin
      #3;
      if (cpu_ready_o) break;
      cyc++;
      if (cyc > 50) begin
        check(0, req, "request never completed", 0, 1);
        break;
      end
      @(negedge clk);
    end
    if (chk_rd) check(cpu_rdata_o == exp, req, "read data", cpu_rdata_o, exp);
    @(posedge clk);
    @(negedge clk);
    cpu_req_i = 0;
    check(exp_q.size() == 0, req, "expected transactions outstanding", exp_q.size(), 0);
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit e_sh, input bit e_sup, input logic [DW-1:0] e_data,
                       input string req);
    @(negedge clk);
    snp_valid_i = 1; snp_cmd_i = cmd; snp_addr_i = a; snp_wdata_i = d;
    #3;
    check(snp_shared_o == e_sh, req, "snoop shared", snp_shared_o, e_sh);
    check(snp_supply_o == e_sup, req, "snoop supply", snp_supply_o, e_sup);
    if (e_sup) check(snp_data_o == e_data, req, "snoop data", snp_data_o, e_data);
    @(negedge clk);
    snp_valid_i = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      check(0, "watchdog", "run hung", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = DW'(16'h1000 + i);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!cpu_ready_o && !bus_req_o && !snp_shared_o && !snp_supply_o, "R1", "outputs in reset",
          {cpu_ready_o, bus_req_o, snp_shared_o, snp_supply_o}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!bus_req_o && !snp_shared_o, "R1", "outputs after reset", {bus_req_o, snp_shared_o}, 0);
    snoop(2'd0, 8'h10, 0, 0, 0, 0, "R1");

    // R2: read miss, sole copy -> exclusive-clean
    shared_cfg = 0; push(2'd0, 8'h10, 0);
    cpu_op(0, 8'h10, 0, 1, 16'h1010, "R2");
    // R4: write on exclusive-clean is silent
    cpu_op(1, 8'h10, 16'ha001, 0, 0, "R4");
    // R8: modified supplies, becomes shared-modified
    snoop(2'd0, 8'h10, 0, 1, 1, 16'ha001, "R8");
    // R5: write on shared-modified sends update
    shared_cfg = 1; push(2'd1, 8'h10, 16'hb002);
    cpu_op(1, 8'h10, 16'hb002, 0, 0, "R5");
    snoop(2'd0, 8'h10, 0, 1, 1, 16'hb002, "R8");
    // R9: snooped update demotes owner to shared-clean
    snoop(2'd1, 8'h10, 16'hc003, 1, 0, 0, "R9");
    snoop(2'd0, 8'h10, 0, 1, 0, 0, "R9");
    cpu_op(0, 8'h10, 0, 1, 16'hc003, "R3");

    // R10: clean victim dropped silently; fill shared -> shared-clean
    shared_cfg = 1; push(2'd0, 8'h14, 0);
    cpu_op(0, 8'h14, 0, 1, 16'h1014, "R10");
    // R5: update with no sharers -> modified
    shared_cfg = 0; push(2'd1, 8'h14, 16'hd004);
    cpu_op(1, 8'h14, 16'hd004, 0, 0, "R5");
    cpu_op(1, 8'h14, 16'he005, 0, 0, "R4");
    // R10: dirty victim written back before the fill
    push(2'd2, 8'h14, 16'he005); push(2'd0, 8'h18, 0);
    cpu_op(0, 8'h18, 0, 1, 16'h1018, "R10");
    push(2'd0, 8'h14, 0);
    cpu_op(0, 8'h14, 0, 1, 16'he005, "R10");

    // R6: write miss into shared line -> fill then update, owner
    shared_cfg = 1; push(2'd0, 8'h21, 0); push(2'd1, 8'h21, 16'hf006);
    cpu_op(1, 8'h21, 16'hf006, 0, 0, "R6");
    shared_cfg = 0; push(2'd2, 8'h21, 16'hf006); push(2'd0, 8'h25, 0);
    cpu_op(0, 8'h25, 0, 1, 16'h1025, "R6");

    // R7: same index, different tag is a miss
    snoop(2'd0, 8'h31, 0, 0, 0, 0, "R7");
    snoop(2'd1, 8'h31, 16'h0bad, 0, 0, 0, "R9");
    cpu_op(0, 8'h25, 0, 1, 16'h1025, "R9");

    // R11: processor hit held off during a snoop cycle
    @(negedge clk);
    cpu_req_i = 1; cpu_we_i = 0; cpu_addr_i = 8'h25;
    snp_valid_i = 1; snp_cmd_i = 2'd0; snp_addr_i = 8'h25;
    #3;
    check(!cpu_ready_o, "R11", "ready during snoop", cpu_ready_o, 0);
    check(snp_shared_o && !snp_supply_o, "R8", "exclusive-clean snoop", {snp_shared_o, snp_supply_o}, 2'b10);
    @(negedge clk);
    snp_valid_i = 0;
    #3;
    check(cpu_ready_o && cpu_rdata_o == 16'h1025, "R11", "ready after snoop", {cpu_ready_o, cpu_rdata_o}, {1'b1, 16'h1025});
    @(negedge clk);
    cpu_req_i = 0;

    // R11: snooped update while own update waits for grant
    shared_cfg = 0; hold_gnt = 1; push(2'd1, 8'h25, 16'h7777);
    fork
      cpu_op(1, 8'h25, 16'h7777, 0, 0, "R11");
      begin
        repeat (3) @(negedge clk);
        snoop(2'd1, 8'h25, 16'h5555, 1, 0, 0, "R11");
        hold_gnt = 0;
      end
    join
    cpu_op(0, 8'h25, 0, 1, 16'h7777, "R11");
    snoop(2'd0, 8'h25, 0, 1, 1, 16'h7777, "R5");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule